// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a 256-byte configuration space for a peripheral controller behind a two-location I/O window. Software first writes a register number to the pointer location, then reads or writes that register through the value location. Every access is a single byte. An external bridge control bit gates the whole window. While it is clear, the window ignores writes and reads back all ones.

Storage is organised by behaviour. Location 0 of the space is the pointer itself, and reading it through the value location gives zero. A fixed set of register numbers is write-protected. A small set of registers is writable, and a few of them load nonzero identification or base-address defaults at reset. Reads are combinational: the byte appears on the read bus in the same cycle as the read strobe.

Top module: `cfg_idx_port`

## Requirements
- R1: After reset the pointer reads 0x00, and the registers read: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. All other registers read 0x00.
- R2: A write with `sel`=0 stores the byte as the pointer. A read with `sel`=0 returns the pointer.
- R3: A write with `sel`=1 stores the byte into the register selected by the pointer, if that register is writable. A later read with `sel`=1 returns it.
- R4: With `sel`=1, writes have no effect at these pointer values: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R5: A read with `sel`=1 while the pointer is 0x00 returns 0x00.
- R6: While `win_en`=0, `rdata` is 0xFF, and writes change neither the pointer nor any register.
- R7: `rdata` is combinational. It is valid in the same cycle that `rd` is high, and it reads 0x00 when `rd` is low and the window is enabled.
- R8: The writable register numbers are 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Window enable from bridge configuration |
| sel | input | 1 | Location select: 0 pointer, 1 value |
| wr | input | 1 | Byte write strobe |
| rd | input | 1 | Byte read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |

## Verification
The hardest case to reach is a protected write. It has no visible effect, so the bench must prove that nothing changed. To do that it fills a writable neighbour with a known value. It then points at a protected number on each edge of every protected range, writes a distinctive byte there, and reads that location and the neighbour back. The disabled-window case needs a similar check. The bench writes to both locations while `win_en` is low, then re-enables the window and reads the pointer and the register back.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;
    localparam int DW = 8;
    localparam int NREG = 256;
    localparam int AW = $clog2(NREG);

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] idx_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PTR  = 2'd1,
        OP_VAL  = 2'd2
    } op_e;

    typedef struct packed {
        op_e   op;
        byte_t data;
    } wreq_t;

    function automatic logic is_writable(idx_t i);
        logic w;
        w = 1'b0;
        if (i >= 8'hE0 && i <= 8'hE3) w = 1'b1;
        if (i >= 8'hE6 && i <= 8'hE8) w = 1'b1;
        if (i >= 8'hEE && i <= 8'hF2) w = 1'b1;
        if (i == 8'hF4 || i == 8'hF6 || i == 8'hF8 || i == 8'hFC) w = 1'b1;
        return w;
    endfunction

    function automatic byte_t reset_val(idx_t i);
        case (i)
            8'hE0: reset_val = 8'h3C;
            8'hE2: reset_val = 8'h03;
            8'hE3: reset_val = 8'hFC;
            8'hE6: reset_val = 8'hDE;
            8'hE7: reset_val = 8'hFE;
            8'hE8: reset_val = 8'hBE;
            default: reset_val = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfg_idx_decode.sv
module cfg_idx_decode
    import cfg_idx_pkg::*;
(
    input  logic  win_en,
    input  logic  sel,
    input  logic  wr,
    input  byte_t wdata,
    output wreq_t req
);
    always_comb begin
        req.data = wdata;
        req.op   = OP_NONE;
        if (win_en && wr) req.op = sel ? OP_VAL : OP_PTR;
    end
endmodule

// File: rtl/cfg_idx_regs.sv
module cfg_idx_regs
    import cfg_idx_pkg::*;
#(
    parameter int BASE = 8'hE0,
    parameter int NUM  = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req,
    input  idx_t  ptr,
    output byte_t rd_val
);
    byte_t store [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        localparam idx_t MY = idx_t'(BASE + g);
        if (is_writable(MY)) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) store[g] <= reset_val(MY);
                else if (req.op == OP_VAL && ptr == MY) store[g] <= req.data;
            end
        end else begin : g_ro
            always_comb store[g] = reset_val(MY);
        end
    end

    always_comb begin
        rd_val = 8'h00;
        if (int'(ptr) >= BASE && int'(ptr) < BASE + NUM)
            rd_val = store[int'(ptr) - BASE];
    end
endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
    import cfg_idx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       win_en,
    input  logic       sel,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    wreq_t req;
    idx_t  ptr_q;
    byte_t reg_val;

    cfg_idx_decode u_dec (
        .win_en(win_en), .sel(sel), .wr(wr), .wdata(wdata), .req(req)
    );

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else if (req.op == OP_PTR) ptr_q <= req.data;
    end

    cfg_idx_regs #(.BASE(8'hE0), .NUM(32)) u_regs (
        .clk(clk), .rst(rst), .req(req), .ptr(ptr_q), .rd_val(reg_val)
    );

    always_comb begin
        if (!win_en)      rdata = 8'hFF;
        else if (!rd)     rdata = 8'h00;
        else if (!sel)    rdata = ptr_q;
        else if (ptr_q == 8'h00) rdata = 8'h00;
        else              rdata = reg_val;
    end
endmodule

module cfg_idx_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       win_en,
    input logic       sel,
    input logic       wr,
    input logic       rd,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] ptr_q
);
    AST_DISABLED_FF: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> rdata == 8'hFF); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(win_en && wr && !sel) |=> $stable(ptr_q)); // R6
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (win_en && wr && !sel) |=> ptr_q == $past(wdata)); // R2
    AST_PTR_READ: assert property (@(posedge clk) disable iff (rst)
        (win_en && rd && !sel) |-> rdata == ptr_q); // R2
    AST_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
        (win_en && rd && sel && ptr_q == 8'h00) |-> rdata == 8'h00); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (win_en && !rd) |-> rdata == 8'h00); // R7
endmodule

bind cfg_idx_port cfg_idx_port_chk u_chk (
    .clk(clk), .rst(rst), .win_en(win_en), .sel(sel), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .ptr_q(ptr_q)
);

// File: tb/cfg_idx_port_bench.sv
module cfg_idx_port_bench;
    logic clk = 0, rst = 1, win_en = 0, sel = 0, wr = 0, rd = 0;
    logic [7:0] wdata = 0, rdata;
    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic mon_go = 0;

    always #10 clk = ~clk;

    cfg_idx_port u_cfg_idx_port (.*);

    task automatic put(input logic s, input logic [7:0] d);
        @(negedge clk); sel = s; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic get(input logic s, input logic [7:0] exp, input string tag);
        @(negedge clk); sel = s; rd = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        mon_go = 1;
        #5; mon_go = 0;
        @(negedge clk); rd = 0;
    endtask

    task automatic rreg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        put(0, a);
        get(1, exp, tag);
    endtask

    always @(posedge mon_go) begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (rdata !== e) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
        end
    end

    function automatic logic wrok(logic [7:0] i);
        return (i >= 8'hE0 && i <= 8'hE3) || (i >= 8'hE6 && i <= 8'hE8) ||
               (i >= 8'hEE && i <= 8'hF2) || i == 8'hF4 || i == 8'hF6 ||
               i == 8'hF8 || i == 8'hFC;
    endfunction

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv [256];
        for (int i = 0; i < 256; i++) rv[i] = 8'h00;
        rv[8'hE0] = 8'h3C; rv[8'hE2] = 8'h03; rv[8'hE3] = 8'hFC;
        rv[8'hE6] = 8'hDE; rv[8'hE7] = 8'hFE; rv[8'hE8] = 8'hBE;
        repeat (3) @(negedge clk);
        rst = 0;
        #1; total++;
        if (rdata !== 8'hFF) begin bad++; $display("FAIL R6 disabled actual=%02h expected=ff", rdata); end
        win_en = 1;
        get(0, 8'h00, "R1 reset pointer");
        for (int i = 8'hE0; i < 256; i++) rreg(8'(i), rv[i], "R1 reset value");
        rreg(8'h10, 8'h00, "R1 low register");
        // R2 pointer write/read
        put(0, 8'hA5); get(0, 8'hA5, "R2 pointer readback");
        // R5 pointer 0 reads zero via value location
        put(0, 8'h00); get(1, 8'h00, "R5 index zero");
        // R3, R8 writable set
        for (int i = 8'hE0; i < 256; i++) begin
            put(0, 8'(i)); put(1, 8'(i ^ 8'h5A));
            get(1, wrok(8'(i)) ? 8'(i ^ 8'h5A) : rv[i],
                wrok(8'(i)) ? "R3 R8 writable" : "R4 protected");
        end
        // R4 protected low range edges
        rreg(8'h00, 8'h00, "R4 idx0");
        put(0, 8'hDF); put(1, 8'h77); get(1, 8'h00, "R4 DF");
        get(0, 8'hDF, "R4 pointer kept");
        put(0, 8'hE1); get(1, 8'hBB, "R4 neighbour E1 intact");
        // R6 disabled writes
        win_en = 0;
        put(0, 8'hF0); put(1, 8'h11);
        @(negedge clk); #1; total++;
        if (rdata !== 8'hFF) begin bad++; $display("FAIL R6 read actual=%02h expected=ff", rdata); end
        win_en = 1;
        get(0, 8'hE1, "R6 pointer unchanged");
        get(1, 8'hBB, "R6 register unchanged");
        // R7 idle bus
        @(negedge clk); sel = 1; #1; total++;
        if (rdata !== 8'h00) begin bad++; $display("FAIL R7 idle actual=%02h expected=00", rdata); end
        // R1 reset again
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        rreg(8'hE2, 8'h03, "R1 re-reset E2");
        rreg(8'hF0, 8'h00, "R1 re-reset F0");
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule